// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the control front end of a synchronous, common-I/O static RAM whose 32-bit words are divided into four bytes. At every rising clock edge it samples a processor address strobe (`adsp_n`), a controller address strobe (`adsc_n`), three chip enables, a burst-advance input, the write controls and the output enable. From these it decides whether an access starts, whether the array is written and which bytes are written, and whether the data bus is driven. It then reports those decisions as an address-load strobe, an array write strobe, a per-byte write mask and a bus drive enable. A small register array stands in for the memory core, so the block can be exercised end to end.

The two strobes start accesses with different write timing. A processor-strobe access loads the address and ignores every write and advance input in that first cycle. The write itself is committed one cycle later. A controller-strobe write is committed in the same cycle that loads the address. After either start, cycles with both strobes high continue the access. An advance input steps a 2-bit burst counter that wraps within a group of four words. A mode input selects whether the counter is added to the two low address bits (linear order) or XORed with them (interleaved order). Read data is registered and appears on the bus in the cycle after the one following address capture.

Top module: `sram_burst_ctrl`

## Requirements
- R1: When `adsp_n` is low at a rising edge with all chip enables active (`ce_a_n`=0, `ce_b`=1, `ce_c_n`=0), `addr_ld` is high in that cycle. In that same cycle `gw_n`, `bwe_n`, `bw_n` and `adv_n` have no effect: `arr_we` stays low and `byte_we` is 0.
- R2: A processor-strobe write is committed on the second rising edge. In the cycle after the start, with both strobes high and a write combination active, `arr_we` is high and `dq_in` is stored at the captured address.
- R3: When `gw_n` is low in a committing cycle, all four bytes are written (`byte_we`=4'hF), whatever `bwe_n` and `bw_n` are.
- R4: With `gw_n` high and `bwe_n` low, `byte_we` equals the inverse of `bw_n`. Bit i controls `dq_in[8i+7:8i]`. Bytes that are not selected keep their contents. With `gw_n` and `bwe_n` both high, or with all `bw_n` bits high, nothing is written.
- R5: With `adsc_n` low, `adsp_n` high, all chip enables active and a write combination active, `addr_ld` and `arr_we` are both high in that same cycle, and `dq_in` is stored at `addr`.
- R6: When both strobes are low in the same cycle, the processor strobe wins. The access starts, and no write occurs in that cycle.
- R7: `dq_oe` is low in every cycle in which `arr_we` is high, even when `oe_n` is low.
- R8: Read data at the captured address is driven on `dq_out` with `dq_oe` high in the cycle after the one following address capture. This happens only when `oe_n` is low and no write is in progress. With `oe_n` high, `dq_oe` is low.
- R9: A strobe that is low at a rising edge while any chip enable is inactive loads no address and ends the access. `dq_oe` is low from the next cycle on.
- R10: Each cycle that continues an access (both strobes high) with `adv_n` low steps the 2-bit burst counter. With `lin_mode`=1 the low address bits are the start bits plus the counter, modulo 4. With `lin_mode`=0 they are the start bits XORed with the counter. The upper address bits do not change.
- R11: The burst counter restarts at 0 on every access start, even when `adv_n` is low in that cycle.
- R12: Reset ends any access. Until a new strobe start occurs, `dq_oe` stays low and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global (all-byte) write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable |
| addr_ld | output | 1 | Address register loads this cycle |
| arr_we | output | 1 | Array write commits this cycle |
| byte_we | output | 4 | Per-byte write mask of the committing write |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a pending read output and a write commit. This is provoked by a processor-strobe write that directly follows a read, so registered read data is waiting while `oe_n` is low. The bus must stay undriven and the write must land, which a later read-back confirms. The second pair is the two address strobes. They are asserted low together with a global write pending; the cycle is judged by `addr_ld` high with `arr_we` low, and by the captured data that is later read back.

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl #(
  parameter int AW      = 17,
  parameter int CORE_AW = 8,
  parameter int NBYTE   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               adsp_n,
  input  logic               adsc_n,
  input  logic               adv_n,
  input  logic               ce_a_n,
  input  logic               ce_b,
  input  logic               ce_c_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [NBYTE-1:0]   bw_n,
  input  logic               oe_n,
  input  logic               lin_mode,
  input  logic [8*NBYTE-1:0] dq_in,
  output logic [8*NBYTE-1:0] dq_out,
  output logic               dq_oe,
  output logic               addr_ld,
  output logic               arr_we,
  output logic [NBYTE-1:0]   byte_we
);
  localparam int DW    = 8 * NBYTE;
  localparam int DEPTH = 1 << CORE_AW;

  logic [DW-1:0]      mem [DEPTH];
  logic [CORE_AW-1:0] base, cur, nxt, wa, ra, ra_d;
  logic [1:0]         cnt;
  logic               active, rd1, rd_v;
  logic               sel, p_go, c_go, desel, cont, wr, rd;
  logic [NBYTE-1:0]   mask;
  logic               unused_hi;

  function automatic logic [1:0] boff(input logic [1:0] b, input logic [1:0] c, input logic lin);
    return lin ? b + c : b ^ c;
  endfunction

  assign unused_hi = ^addr[AW-1:CORE_AW];

  assign sel   = !ce_a_n && ce_b && !ce_c_n;
  assign p_go  = !adsp_n && sel;
  assign c_go  = adsp_n && !adsc_n && sel;
  assign desel = (!adsp_n || !adsc_n) && !sel;
  assign cont  = active && adsp_n && adsc_n;

  assign mask = !gw_n ? {NBYTE{1'b1}} : (!bwe_n ? ~bw_n : '0);
  assign wr   = (c_go || cont) && (|mask);
  assign rd   = p_go || ((c_go || cont) && !wr);

  assign cur  = {base[CORE_AW-1:2], boff(base[1:0], cnt, lin_mode)};
  assign nxt  = {base[CORE_AW-1:2], boff(base[1:0], cnt + 2'd1, lin_mode)};
  assign wa   = c_go ? addr[CORE_AW-1:0] : cur;
  assign ra_d = (p_go || c_go) ? addr[CORE_AW-1:0] : (!adv_n ? nxt : cur);

  assign addr_ld = p_go || c_go;
  assign arr_we  = wr;
  assign byte_we = wr ? mask : '0;
  assign dq_oe   = rd_v && !oe_n && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      rd1    <= 1'b0;
      rd_v   <= 1'b0;
      ra     <= '0;
    end else begin
      if (p_go || c_go) begin
        base   <= addr[CORE_AW-1:0];
        cnt    <= '0;
        active <= 1'b1;
      end else if (desel) begin
        active <= 1'b0;
      end else if (cont && !adv_n) begin
        cnt <= cnt + 2'd1;
      end
      rd1  <= rd;
      ra   <= ra_d;
      rd_v <= rd1 && !wr && !desel;
    end
  end

  always_ff @(posedge clk) begin
    if (rd1) dq_out <= mem[ra];
    for (int i = 0; i < NBYTE; i++)
      if (byte_we[i]) mem[wa][8*i +: 8] <= dq_in[8*i +: 8];
  end
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk #(
  parameter int NBYTE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             ce_a_n,
  input logic             ce_b,
  input logic             ce_c_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic             addr_ld,
  input logic             arr_we,
  input logic [NBYTE-1:0] byte_we,
  input logic             dq_oe
);
  logic en;
  assign en = !ce_a_n && ce_b && !ce_c_n;

  assert_pstart_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && en) |-> (addr_ld && !arr_we && byte_we == '0));

  assert_global_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !gw_n) |-> (byte_we == {NBYTE{1'b1}}));

  assert_mask_needs_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we != '0) |-> arr_we);

  assert_both_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !adsc_n) |-> !arr_we);

  assert_write_busoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !dq_oe);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  assert_desel_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!adsp_n || !adsc_n) && !en) |=> !dq_oe);

  assert_desel_noload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!adsp_n || !adsc_n) && !en) |-> !addr_ld);
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(.NBYTE(NBYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
  .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .gw_n(gw_n), .oe_n(oe_n),
  .addr_ld(addr_ld), .arr_we(arr_we), .byte_we(byte_we), .dq_oe(dq_oe)
);

// File: tb/sram_burst_ctrl_test.sv
module sram_burst_ctrl_test;
  localparam int AW = 17;
  localparam int NV = 34;

  typedef struct packed {
    logic p, c, v, s, g, b;
    logic [3:0] w;
    logic o, l;
    logic [7:0] a;
    logic [31:0] d;
    logic eld, ewe;
    logic [3:0] ebw;
    logic eoe;
    logic [31:0] edo;
  } vec_t;

  localparam vec_t TAB [NV] = '{
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,0,'h0},
    '{1,0,1,1,0,1,'hF,0,1,'h11,'hA5A5A5A5, 1,1,'hF,0,'h0},
    '{1,0,1,1,1,0,'hA,0,1,'h11,'h12345678, 1,1,'h5,0,'h0},
    '{0,1,0,1,0,1,'hF,0,1,'h11,'h0,        1,0,'h0,0,'h0},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,0,'h0},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'hA534A578},
    '{1,1,1,1,1,1,'hF,1,1,'h00,'h0,        0,0,'h0,0,'h0},
    '{0,1,1,1,1,1,'hF,0,1,'h20,'h0,        1,0,'h0,1,'hA534A578},
    '{1,1,1,1,0,1,'hF,0,1,'h00,'hCAFEF00D, 0,1,'hF,0,'h0},
    '{0,0,1,1,0,1,'hF,0,1,'h20,'h0,        1,0,'h0,0,'h0},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,0,'h0},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'hCAFEF00D},
    '{0,1,1,0,1,1,'hF,0,1,'h20,'h0,        0,0,'h0,1,'hCAFEF00D},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,0,'h0},
    '{1,0,1,1,0,1,'hF,0,1,'h40,'h40,       1,1,'hF,0,'h0},
    '{1,0,1,1,0,1,'hF,0,1,'h41,'h41,       1,1,'hF,0,'h0},
    '{1,0,1,1,0,1,'hF,0,1,'h42,'h42,       1,1,'hF,0,'h0},
    '{1,0,1,1,0,1,'hF,0,1,'h43,'h43,       1,1,'hF,0,'h0},
    '{0,1,1,1,1,1,'hF,0,1,'h41,'h0,        1,0,'h0,0,'h0},
    '{1,1,0,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,0,'h0},
    '{1,1,0,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'h41},
    '{1,1,0,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'h42},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'h43},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'h40},
    '{0,1,1,1,1,1,'hF,0,0,'h41,'h0,        1,0,'h0,1,'h40},
    '{1,1,0,1,1,1,'hF,0,0,'h00,'h0,        0,0,'h0,1,'h40},
    '{1,1,0,1,1,1,'hF,0,0,'h00,'h0,        0,0,'h0,1,'h41},
    '{1,1,0,1,1,1,'hF,0,0,'h00,'h0,        0,0,'h0,1,'h40},
    '{1,1,1,1,1,1,'hF,0,0,'h00,'h0,        0,0,'h0,1,'h43},
    '{1,1,1,1,1,1,'hF,0,0,'h00,'h0,        0,0,'h0,1,'h42},
    '{1,1,1,1,1,1,'hF,0,0,'h00,'h0,        0,0,'h0,1,'h42},
    '{1,0,1,1,1,0,'hF,0,1,'h11,'hFFFFFFFF, 1,0,'h0,1,'h42},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'h42},
    '{1,1,1,1,1,1,'hF,0,1,'h00,'h0,        0,0,'h0,1,'hA534A578}
  };

  localparam string TAG [NV] = '{
    "R12 idle", "R5 R3", "R5 R4", "R1 R11", "R8", "R8 R4", "R8 oe_n", "R1 R8",
    "R2 R7", "R6", "R8", "R2 R8", "R9", "R9", "R5", "R5", "R5", "R5",
    "R1", "R10", "R10 R11", "R10", "R10", "R10", "R10", "R10", "R10", "R10",
    "R10", "R10", "R10", "R4 R5", "R4", "R4"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, lin_mode = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic dq_oe, addr_ld, arr_we;
  logic [3:0] byte_we;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_burst_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .lin_mode(lin_mode), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .addr_ld(addr_ld), .arr_we(arr_we),
    .byte_we(byte_we)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    adsp_n = t.p; adsc_n = t.c; adv_n = t.v;
    ce_a_n = !t.s; ce_b = t.s; ce_c_n = !t.s;
    gw_n = t.g; bwe_n = t.b; bw_n = t.w; oe_n = t.o; lin_mode = t.l;
    addr = {9'h0, t.a}; dq_in = t.d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    drive(TAB[0]);
    repeat (3) @(negedge clk);
    #2;
    check("R12", "dq_oe in reset", {31'b0, dq_oe}, 32'd0);
    check("R12", "arr_we in reset", {31'b0, arr_we}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TAB[i]);
      #2;
      check(TAG[i], "addr_ld", {31'b0, addr_ld}, {31'b0, TAB[i].eld});
      check(TAG[i], "arr_we", {31'b0, arr_we}, {31'b0, TAB[i].ewe});
      check(TAG[i], "byte_we", {28'b0, byte_we}, {28'b0, TAB[i].ebw});
      check(TAG[i], "dq_oe", {31'b0, dq_oe}, {31'b0, TAB[i].eoe});
      if (TAB[i].eoe) check(TAG[i], "dq_out", dq_out, TAB[i].edo);
    end

    // R12: reset in the middle of a read session, then a continue cycle with a global write
    @(negedge clk);
    rst_n = 1'b0;
    drive(TAB[4]);
    #2;
    check("R12", "dq_oe during reset", {31'b0, dq_oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(TAB[8]);
    #2;
    check("R12", "arr_we after reset", {31'b0, arr_we}, 32'd0);
    check("R12", "dq_oe after reset", {31'b0, dq_oe}, 32'd0);

    // R9: deselect through the controller strobe ends a read
    @(negedge clk); drive(TAB[18]);
    @(negedge clk); drive(TAB[4]);
    @(negedge clk); drive(TAB[4]); #2;
    check("R8", "dq_oe before deselect", {31'b0, dq_oe}, 32'd1);
    check("R8", "dq_out before deselect", dq_out, 32'h41);
    @(negedge clk);
    drive(TAB[4]); adsc_n = 1'b0; ce_b = 1'b0; #2;
    check("R9", "addr_ld on deselect", {31'b0, addr_ld}, 32'd0);
    @(negedge clk); drive(TAB[4]); #2;
    check("R9", "dq_oe after deselect", {31'b0, dq_oe}, 32'd0);
    check("R9", "arr_we after deselect", {31'b0, arr_we}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule